// File: doc/BRIEF.md
# Parallel ATA PIO Host Cycle Sequencer

This block runs one register or data-port access at a time on a parallel ATA bus from the host side. A request carries the two chip-select bits, the 3-bit register address, the direction, the write word and a transfer mode from 0 to 4. The sequencer then drives the chip selects and address lines, the read or write strobe, and the data bus for writes. For reads it captures the data bus. When the access is complete it raises a single-clock completion pulse.

Each mode's timing limits are given in nanoseconds. At elaboration they are converted to whole clocks of the system clock, always rounding up. The block spaces the address setup, the strobe width, the address and data hold, and a recovery pad so that a cycle is never shorter than the mode allows. The device's ready line passes through a synchronizer and is sampled once, a fixed 35 ns after the strobe asserts. If the line is low at that instant, the strobe is held asserted until the line returns high. A watchdog on this wait ends the cycle after 1250 ns and reports an error.

Top module: `ata_pio_host`

## Requirements
- R1: After reset both chip selects and both strobes are negated (high), the data bus driver is off, and busy, done and timeout_err are low.
- R2: The DMA acknowledge output stays high at all times.
- R3: The chip selects (ata_cs_n = ~req_cs) and address (ata_da = req_addr) become valid on the clock edge that accepts a request. The strobe asserts exactly SU clocks later, where SU = ceil(t/period) with t = 70, 50, 30, 30, 25 ns for modes 0..4.
- R4: When the ready line is high at the sample point, the strobe stays low for exactly ACT clocks, where ACT = ceil(max(165,60), max(125,45), 100, 80, 70 ns / period) for modes 0..4. Writes use ata_diow_n and reads use ata_dior_n.
- R5: After the strobe negates, the chip selects, the address and (for writes) the driven data stay valid for HOLD = max(ceil(address hold), ceil(data hold)) clocks, with address hold 20, 15, 10, 10, 10 ns and data hold 30, 20, 15, 10, 10 ns. After that the chip selects return to 2'b11.
- R6: done is a one-clock pulse. When no wait occurs it follows acceptance after max(CYC, SU+ACT+HOLD) clocks, where CYC = ceil(600, 383, 240, 180, 120 ns / period). After a stretched strobe the recovery pad is unchanged.
- R7: The ready input passes through a 2-stage synchronizer and is evaluated once, ceil(35 ns/period)+2 clocks after the strobe asserts. If it is low there, the strobe stays low until it is seen high, and then negates on the following clock. The strobe is never shorter than ACT.
- R8: A low level on the ready line that does not cover the sample instant has no effect on the strobe width.
- R9: If the wait lasts more than ceil(1250 ns/period) clocks after the low sample, the strobe negates, the cycle completes normally, and timeout_err pulses together with done.
- R10: ata_dd_oe is high only during a write cycle while the chip selects are asserted, and ata_dd_out then carries req_wdata. During a read it stays low, and the unused strobe stays high.
- R11: For reads, rdata holds the value of ata_dd_in on the clock edge where the read strobe negates. Later bus changes do not alter it.
- R12: Mode codes 5 to 7 produce the same timing as mode 4.
- R13: A req_start pulse while busy is ignored: the address and data of the running cycle do not change and no second cycle follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start a cycle (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 2 | Chip-select bits, active high |
| req_addr | input | 3 | Register address |
| req_wdata | input | DATA_W | Write word |
| req_mode | input | 3 | Transfer mode, 0..4 (5..7 act as 4) |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock completion pulse |
| timeout_err | output | 1 | Wait watchdog fired (with done) |
| rdata | output | DATA_W | Captured read word |
| ata_cs_n | output | 2 | Chip selects, active low |
| ata_da | output | 3 | Device address lines |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dmack_n | output | 1 | DMA acknowledge, held negated |
| ata_iordy | input | 1 | Device ready (asynchronous) |
| ata_dd_in | input | DATA_W | Data bus input |
| ata_dd_out | output | DATA_W | Data bus output value |
| ata_dd_oe | output | 1 | Data bus output enable |

## Verification
The hardest situations to reach from the ports are the ones where the ready line changes near the single sample instant or near the watchdog limit. After the synchronizer, one clock makes the difference between no wait, a wait, and a timeout. The bench counts clocks from the accepting edge and drives the ready line low over windows placed relative to the sample clock that the bench derives itself. The windows are: wholly before it, wholly after it, covering it with a release at a chosen offset, and covering it past the limit. Random cycles mix these windows over all eight mode codes and both directions.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  localparam int NUM_MODES       = 5;
  localparam int TIMING_W        = 12;
  localparam int IORDY_SAMPLE_NS = 35;
  localparam int WAIT_LIMIT_NS   = 1250;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_STROBE  = 3'd2,
    ST_HOLD    = 3'd3,
    ST_RECOVER = 3'd4
  } pio_state_e;

  typedef struct packed {
    logic [TIMING_W-1:0] setup;
    logic [TIMING_W-1:0] active;
    logic [TIMING_W-1:0] hold;
    logic [TIMING_W-1:0] recover;
  } pio_timing_t;

  // whole clocks covering ns, rounded up
  function automatic int clocks_for(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int min_cycle_ns(input int m);
    case (m)
      0:       return 600;
      1:       return 383;
      2:       return 240;
      3:       return 180;
      default: return 120;
    endcase
  endfunction

  function automatic int addr_setup_ns(input int m);
    case (m)
      0:       return 70;
      1:       return 50;
      2:       return 30;
      3:       return 30;
      default: return 25;
    endcase
  endfunction

  function automatic int strobe_width_ns(input int m);
    case (m)
      0:       return 165;
      1:       return 125;
      2:       return 100;
      3:       return 80;
      default: return 70;
    endcase
  endfunction

  function automatic int wdata_setup_ns(input int m);
    case (m)
      0:       return 60;
      1:       return 45;
      2:       return 30;
      3:       return 30;
      default: return 20;
    endcase
  endfunction

  function automatic int addr_hold_ns(input int m);
    case (m)
      0:       return 20;
      1:       return 15;
      default: return 10;
    endcase
  endfunction

  function automatic int wdata_hold_ns(input int m);
    case (m)
      0:       return 30;
      1:       return 20;
      2:       return 15;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/ata_pio_timing.sv
module ata_pio_timing
  import ata_pio_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 4,
  parameter int MODE_W        = 3
) (
  input  logic [MODE_W-1:0] mode,
  output pio_timing_t       timing
);

  pio_timing_t mode_tbl [NUM_MODES];

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    localparam int SU  = clocks_for(addr_setup_ns(m), CLK_PERIOD_NS);
    localparam int ACT = clocks_for(max_of(strobe_width_ns(m), wdata_setup_ns(m)), CLK_PERIOD_NS);
    localparam int AH  = clocks_for(addr_hold_ns(m), CLK_PERIOD_NS);
    localparam int DH  = clocks_for(wdata_hold_ns(m), CLK_PERIOD_NS);
    localparam int HLD = max_of(max_of(AH, DH), 1);
    localparam int CYC = clocks_for(min_cycle_ns(m), CLK_PERIOD_NS);
    localparam int REC = (CYC > SU + ACT + HLD) ? (CYC - SU - ACT - HLD) : 0;

    assign mode_tbl[m].setup   = TIMING_W'(max_of(SU, 1));
    assign mode_tbl[m].active  = TIMING_W'(ACT);
    assign mode_tbl[m].hold    = TIMING_W'(HLD);
    assign mode_tbl[m].recover = TIMING_W'(REC);
  end

  logic [MODE_W-1:0] sel;

  always_comb begin
    sel    = (mode >= MODE_W'(NUM_MODES)) ? MODE_W'(NUM_MODES - 1) : mode;
    timing = mode_tbl[sel];
  end

endmodule

// File: rtl/ata_pio_sync.sv
module ata_pio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= (chain << 1) | STAGES'(d);
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/ata_pio_fsm.sv
module ata_pio_fsm
  import ata_pio_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  pio_timing_t timing,
  input  logic        ready_s,
  output pio_state_e  state,
  output logic        accept,
  output logic        strobe_end,
  output logic        done,
  output logic        timeout_err
);

  localparam int SAMPLE_CLK = clocks_for(IORDY_SAMPLE_NS, CLK_PERIOD_NS) + SYNC_STAGES;
  localparam int WAIT_CLK   = clocks_for(WAIT_LIMIT_NS, CLK_PERIOD_NS);
  localparam int WAIT_W     = $clog2(WAIT_CLK + 1);

  pio_state_e          st_q, st_d;
  logic [TIMING_W-1:0] cnt_q;
  logic [WAIT_W-1:0]   wait_cnt_q;
  logic                wait_q, late_err_q, done_q, err_q;
  logic                sample_now, miss, release_w, expire, finishing;

  always_comb begin
    sample_now = (st_q == ST_STROBE) && (cnt_q == TIMING_W'(SAMPLE_CLK - 1));
    miss       = sample_now && !ready_s;
    release_w  = wait_q && ready_s;
    expire     = wait_q && !ready_s && (wait_cnt_q == WAIT_W'(WAIT_CLK - 1));
    strobe_end = (st_q == ST_STROBE) &&
                 (expire || ((cnt_q >= timing.active - 1'b1) && !wait_q && !miss));
    accept     = (st_q == ST_IDLE) && start;
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:    if (start) st_d = ST_SETUP;
      ST_SETUP:   if (cnt_q == timing.setup - 1'b1) st_d = ST_STROBE;
      ST_STROBE:  if (strobe_end) st_d = ST_HOLD;
      ST_HOLD:    if (cnt_q == timing.hold - 1'b1)
                    st_d = (timing.recover != '0) ? ST_RECOVER : ST_IDLE;
      ST_RECOVER: if (cnt_q == timing.recover - 1'b1) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
    finishing = (st_q != ST_IDLE) && (st_d == ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      wait_q     <= 1'b0;
      wait_cnt_q <= '0;
      late_err_q <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      st_q <= st_d;

      if (st_d != st_q)      cnt_q <= '0;
      else if (cnt_q != '1)  cnt_q <= cnt_q + 1'b1;

      if (st_q != ST_STROBE)  wait_q <= 1'b0;
      else if (miss)          wait_q <= 1'b1;
      else if (release_w)     wait_q <= 1'b0;
      else if (expire)        wait_q <= 1'b0;

      if (wait_q) wait_cnt_q <= wait_cnt_q + 1'b1;
      else        wait_cnt_q <= '0;

      if (accept)      late_err_q <= 1'b0;
      else if (expire) late_err_q <= 1'b1;

      done_q <= finishing;
      err_q  <= finishing && late_err_q;
    end
  end

  assign state       = st_q;
  assign done        = done_q;
  assign timeout_err = err_q;

endmodule

// File: rtl/ata_pio_bus.sv
module ata_pio_bus
  import ata_pio_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  parameter int CS_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              strobe_end,
  input  pio_state_e        state,
  input  logic              req_write,
  input  logic [CS_W-1:0]   req_cs,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dd_in,
  output logic [CS_W-1:0]   cs_n,
  output logic [ADDR_W-1:0] da,
  output logic              dior_n,
  output logic              diow_n,
  output logic [DATA_W-1:0] dd_out,
  output logic              dd_oe,
  output logic [DATA_W-1:0] rdata
);

  logic              wr_q;
  logic [CS_W-1:0]   cs_q;
  logic [ADDR_W-1:0] da_q;
  logic [DATA_W-1:0] wd_q, rd_q;
  logic              addr_on, strobing;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= 1'b0;
      cs_q <= '0;
      da_q <= '0;
      wd_q <= '0;
      rd_q <= '0;
    end else begin
      if (accept) begin
        wr_q <= req_write;
        cs_q <= req_cs;
        da_q <= req_addr;
        wd_q <= req_wdata;
      end
      if (strobe_end && !wr_q) rd_q <= dd_in;
    end
  end

  always_comb begin
    addr_on  = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
    strobing = (state == ST_STROBE);
    cs_n     = addr_on ? ~cs_q : '1;
    da       = da_q;
    dior_n   = !(strobing && !wr_q);
    diow_n   = !(strobing && wr_q);
    dd_oe    = addr_on && wr_q;
    dd_out   = wd_q;
    rdata    = rd_q;
  end

endmodule

// File: rtl/ata_pio_host.sv
module ata_pio_host
  import ata_pio_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 4,
  parameter int DATA_W        = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_start,
  input  logic              req_write,
  input  logic [1:0]        req_cs,
  input  logic [2:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [2:0]        req_mode,
  output logic              busy,
  output logic              done,
  output logic              timeout_err,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        ata_cs_n,
  output logic [2:0]        ata_da,
  output logic              ata_dior_n,
  output logic              ata_diow_n,
  output logic              ata_dmack_n,
  input  logic              ata_iordy,
  input  logic [DATA_W-1:0] ata_dd_in,
  output logic [DATA_W-1:0] ata_dd_out,
  output logic              ata_dd_oe
);

  localparam int MODE_W = 3;

  pio_state_e        state;
  pio_timing_t       timing;
  logic              accept, strobe_end, ready_s;
  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk) begin
    if (rst)         mode_q <= MODE_W'(NUM_MODES - 1);
    else if (accept) mode_q <= req_mode;
  end

  ata_pio_timing #(.CLK_PERIOD_NS(CLK_PERIOD_NS), .MODE_W(MODE_W)) u_timing (
    .mode   (mode_q),
    .timing (timing)
  );

  ata_pio_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ata_iordy),
    .q   (ready_s)
  );

  ata_pio_fsm #(.CLK_PERIOD_NS(CLK_PERIOD_NS), .SYNC_STAGES(SYNC_STAGES)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start       (req_start),
    .timing      (timing),
    .ready_s     (ready_s),
    .state       (state),
    .accept      (accept),
    .strobe_end  (strobe_end),
    .done        (done),
    .timeout_err (timeout_err)
  );

  ata_pio_bus #(.DATA_W(DATA_W), .ADDR_W(3), .CS_W(2)) u_bus (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .strobe_end (strobe_end),
    .state      (state),
    .req_write  (req_write),
    .req_cs     (req_cs),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .dd_in      (ata_dd_in),
    .cs_n       (ata_cs_n),
    .da         (ata_da),
    .dior_n     (ata_dior_n),
    .diow_n     (ata_diow_n),
    .dd_out     (ata_dd_out),
    .dd_oe      (ata_dd_oe),
    .rdata      (rdata)
  );

  assign busy        = (state != ST_IDLE);
  assign ata_dmack_n = 1'b1;

endmodule

// File: rtl/ata_pio_host_chk.sv
module ata_pio_host_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       timeout_err,
  input logic [1:0] ata_cs_n,
  input logic [2:0] ata_da,
  input logic       ata_dior_n,
  input logic       ata_diow_n,
  input logic       ata_dmack_n,
  input logic       ata_dd_oe
);

  a_r2_dmack_negated: assert property (@(posedge clk) disable iff (rst)
    ata_dmack_n);

  a_r10_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!ata_dior_n && !ata_diow_n));

  a_r3_cs_before_strobe: assert property (@(posedge clk) disable iff (rst)
    $fell(ata_dior_n && ata_diow_n) |-> $past(ata_cs_n) != 2'b11);

  a_r5_cs_after_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(ata_dior_n && ata_diow_n) |-> ata_cs_n != 2'b11);

  a_r10_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
    !ata_dior_n |-> !ata_dd_oe);

  a_r10_drive_needs_cs: assert property (@(posedge clk) disable iff (rst)
    ata_dd_oe |-> ata_cs_n != 2'b11);

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_done_when_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r9_err_with_done: assert property (@(posedge clk) disable iff (rst)
    timeout_err |-> done);

  a_r13_addr_steady: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(ata_da));

endmodule

bind ata_pio_host ata_pio_host_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .busy        (busy),
  .done        (done),
  .timeout_err (timeout_err),
  .ata_cs_n    (ata_cs_n),
  .ata_da      (ata_da),
  .ata_dior_n  (ata_dior_n),
  .ata_diow_n  (ata_diow_n),
  .ata_dmack_n (ata_dmack_n),
  .ata_dd_oe   (ata_dd_oe)
);

// File: tb/ata_pio_host_bench.sv
module ata_pio_host_bench;

  localparam int P = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_start, req_write;
  logic [1:0]    req_cs;
  logic [2:0]    req_addr, req_mode;
  logic [DW-1:0] req_wdata;
  logic          busy, done, timeout_err;
  logic [DW-1:0] rdata;
  logic [1:0]    ata_cs_n;
  logic [2:0]    ata_da;
  logic          ata_dior_n, ata_diow_n, ata_dmack_n, ata_iordy;
  logic [DW-1:0] ata_dd_in, ata_dd_out;
  logic          ata_dd_oe;

  always #2 clk = ~clk;

  ata_pio_host #(.CLK_PERIOD_NS(P), .DATA_W(DW)) u_ata_pio_host (
    .clk(clk), .rst(rst), .req_start(req_start), .req_write(req_write),
    .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata), .req_mode(req_mode),
    .busy(busy), .done(done), .timeout_err(timeout_err), .rdata(rdata),
    .ata_cs_n(ata_cs_n), .ata_da(ata_da), .ata_dior_n(ata_dior_n),
    .ata_diow_n(ata_diow_n), .ata_dmack_n(ata_dmack_n), .ata_iordy(ata_iordy),
    .ata_dd_in(ata_dd_in), .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe)
  );

  int n_vec = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ck(input int ns);
    return (ns + P - 1) / P;
  endfunction
  function automatic int mx(input int a, input int b);
    return a > b ? a : b;
  endfunction
  function automatic int t_su(input int m);
    int v[5] = '{70, 50, 30, 30, 25};
    return v[m];
  endfunction
  function automatic int t_act(input int m);
    int w[5] = '{165, 125, 100, 80, 70};
    int s[5] = '{60, 45, 30, 30, 20};
    return mx(w[m], s[m]);
  endfunction
  function automatic int t_hold_clk(input int m);
    int a[5] = '{20, 15, 10, 10, 10};
    int d[5] = '{30, 20, 15, 10, 10};
    return mx(ck(a[m]), ck(d[m]));
  endfunction
  function automatic int t_cyc(input int m);
    int c[5] = '{600, 383, 240, 180, 120};
    return c[m];
  endfunction

  // kind: 0 none, 1 low before sample, 2 low after sample, 3 wait released after w, 4 timeout
  task automatic run_cycle(input bit wr, input logic [1:0] cs, input logic [2:0] a,
                           input logic [DW-1:0] wd, input logic [DW-1:0] rdv,
                           input logic [2:0] md, input int kind, input int w, input bit poke);
    int m, su, act, hld, cyc, rec, iord, tmo, ks, lo_a, lo_b;
    int exp_rise, k, fall, rise, csoff, dn;
    bit exp_err, got_err;
    logic [DW-1:0] got_rd;
    string rtag, ftag;
    m    = (md > 3'd4) ? 4 : int'(md);
    su   = ck(t_su(m));
    act  = ck(t_act(m));
    hld  = t_hold_clk(m);
    cyc  = ck(t_cyc(m));
    rec  = (cyc > su + act + hld) ? cyc - su - act - hld : 0;
    iord = ck(35);
    tmo  = ck(1250);
    ks   = su + iord;
    lo_a = 0; lo_b = 0;
    case (kind)
      1: begin lo_a = su + 1;  lo_b = ks - 1; end
      2: begin lo_a = ks + 1;  lo_b = su + act; end
      3: begin lo_a = su + 2;  lo_b = ks + 1 + w; end
      4: begin lo_a = su + 2;  lo_b = 1 << 30; end
      default: ;
    endcase
    exp_err = 1'b0;
    if (ks >= lo_a && ks < lo_b) begin
      if (lo_b - ks > tmo) begin exp_rise = ks + 3 + tmo; exp_err = 1'b1; end
      else exp_rise = mx(su + act + 1, lo_b + 4);
    end else exp_rise = su + act + 1;
    rtag = (kind == 4) ? "R9" : (kind == 3) ? "R7" : (kind != 0) ? "R8" : "R4";
    ftag = (md > 3'd4) ? "R12" : "R3";

    @(negedge clk);
    req_write = wr; req_cs = cs; req_addr = a; req_wdata = wd; req_mode = md;
    ata_dd_in = rdv; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    k = 1; fall = -1; rise = -1; csoff = -1; dn = -1;
    got_err = 1'b0; got_rd = '0;
    while (dn < 0 && k < 2000) begin
      ata_iordy = !(k >= lo_a && k < lo_b);
      if (fall < 0 && (wr ? !ata_diow_n : !ata_dior_n)) fall = k;
      if (fall >= 0 && rise < 0 && (wr ? ata_diow_n : ata_dior_n)) begin
        rise = k;
        ata_dd_in = ~rdv;
      end
      if (rise >= 0 && csoff < 0 && ata_cs_n == 2'b11) csoff = k;
      if (done) begin dn = k; got_err = timeout_err; got_rd = rdata; end
      if (k == su + 2) begin
        check(ata_cs_n == ~cs, poke ? "R13" : "R3", "cs_n during cycle", ata_cs_n, ~cs);
        check(ata_da == a, poke ? "R13" : "R3", "address during cycle", ata_da, a);
        check(ata_dd_oe == wr, "R10", "data drive enable", ata_dd_oe, wr);
        if (wr) check(ata_dd_out == wd, poke ? "R13" : "R10", "write data", ata_dd_out, wd);
        check((wr ? ata_dior_n : ata_diow_n) == 1'b1, "R10", "unused strobe", 0, 1);
        check(ata_dmack_n == 1'b1, "R2", "dmack", ata_dmack_n, 1);
      end
      if (poke && k == 2) begin
        req_start = 1'b1; req_addr = ~a; req_wdata = ~wd; req_write = ~wr;
      end else req_start = 1'b0;
      @(negedge clk);
      k++;
    end
    ata_iordy = 1'b1;
    check(fall == su + 1, ftag, "strobe assert clock", fall, su + 1);
    check(rise == exp_rise, rtag, "strobe negate clock", rise, exp_rise);
    check(csoff == exp_rise + hld, "R5", "cs release clock", csoff, exp_rise + hld);
    check(dn == exp_rise + hld + rec, "R6", "done clock", dn, exp_rise + hld + rec);
    check(got_err == exp_err, "R9", "timeout flag", got_err, exp_err);
    if (!wr) check(got_rd == rdv, "R11", "read data", got_rd, rdv);
    @(negedge clk);
    check(!done && !busy, poke ? "R13" : "R6", "idle after done", {done, busy}, 0);
    if (!wr) check(rdata == rdv, "R11", "read data kept", rdata, rdv);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd5150);
    rst = 1'b1; req_start = 1'b0; req_write = 1'b0; req_cs = 2'b00; req_addr = '0;
    req_wdata = '0; req_mode = '0; ata_iordy = 1'b1; ata_dd_in = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ata_cs_n == 2'b11, "R1", "reset cs_n", ata_cs_n, 3);
    check(ata_dior_n && ata_diow_n, "R1", "reset strobes", {ata_dior_n, ata_diow_n}, 3);
    check(!ata_dd_oe && !busy && !done && !timeout_err, "R1", "reset flags",
          {ata_dd_oe, busy, done, timeout_err}, 0);
    check(ata_dmack_n, "R2", "reset dmack", ata_dmack_n, 1);

    run_cycle(1'b1, 2'b01, 3'd0, 16'hA55A, 16'h0000, 3'd0, 0, 0, 1'b0); // R4 mode 0 write
    run_cycle(1'b0, 2'b01, 3'd7, 16'h0000, 16'h1234, 3'd4, 0, 0, 1'b0); // R11 mode 4 read
    run_cycle(1'b1, 2'b10, 3'd6, 16'hFFFF, 16'h0000, 3'd1, 0, 0, 1'b0);
    run_cycle(1'b0, 2'b01, 3'd2, 16'h0000, 16'hBEEF, 3'd2, 1, 0, 1'b0); // R8 early low
    run_cycle(1'b0, 2'b01, 3'd3, 16'h0000, 16'h0F0F, 3'd3, 2, 0, 1'b0); // R8 late low
    run_cycle(1'b1, 2'b01, 3'd1, 16'h5A5A, 16'h0000, 3'd4, 3, 2, 1'b0); // R7 short wait
    run_cycle(1'b0, 2'b01, 3'd5, 16'h0000, 16'hC3C3, 3'd4, 3, 20, 1'b0); // R7 long wait
    run_cycle(1'b0, 2'b01, 3'd4, 16'h0000, 16'h7E7E, 3'd4, 4, 0, 1'b0); // R9 timeout
    run_cycle(1'b1, 2'b10, 3'd3, 16'h0001, 16'h0000, 3'd6, 0, 0, 1'b0); // R12
    run_cycle(1'b1, 2'b01, 3'd5, 16'h8001, 16'h0000, 3'd2, 0, 0, 1'b1); // R13 poke

    for (int i = 0; i < 40; i++) begin
      logic [31:0] r;
      int kd;
      r  = $urandom;
      kd = int'(r[10:8] % 4);
      run_cycle(r[0], r[1] ? 2'b10 : 2'b01, r[4:2], $urandom, $urandom, r[7:5],
                kd, int'(r[16:11] % 41), r[20]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule